// File: doc/BRIEF.md
# Byte ALU with Selective Flag Update

This block is the combinational arithmetic and logic unit of a small load/store microcontroller datapath. The caller supplies two operands, already muxed so that the second one is either a register value or an immediate. It also supplies the current status byte and a 5-bit operation code. In the same cycle the block returns the result, a result write-enable for the register file and the next status byte.

Each operation rewrites only its own set of flags: carry (C), zero (Z), negative (N), two's-complement overflow (V), sign (S) and half carry (H). Every other flag passes through unchanged. The two upper status bits belong to other units and are never touched. Compare operations set flags without writing a result. The chained forms of subtract and compare can only keep or clear Z, so a multi-byte compare works one byte after another.

The block holds no state. It has no clock and so no state machine. Operation selection is one enumerated `unique case`, and the same case decides which flags are updated.

Top module: `alu8_core`

## Requirements
- R1: Opcodes 0 (add) and 1 (add plus incoming C) write the sum. C is the carry out of the MSB, H is the carry out of bit 3, V is signed overflow, N is the result MSB and Z is set when the result is all zeros.
- R2: Opcode 2 (subtract) writes opa - opb. C and H are the borrows out of the MSB and out of bit 3, and V is signed overflow of the difference. Opcode 3 (subtract with borrow) writes opa - opb - C with the same flag rules.
- R3: For opcodes 3 and 12, Z becomes 1 only if the difference is zero and Z was already 1. Otherwise Z becomes 0.
- R4: Opcodes 4 (AND), 5 (OR) and 6 (XOR) write the bitwise result, clear V, update Z and N, and keep C and H.
- R5: Opcode 7 writes the ones' complement of opa. It sets C to 1, clears V, updates Z and N, and keeps H.
- R6: Opcode 8 writes 0 - opa. C is 1 unless opa is zero, H is the borrow out of bit 3, and V is 1 only when opa is 0x80.
- R7: Opcodes 9 (increment) and 10 (decrement) write opa+1 and opa-1 and keep C and H. V is 1 only when incrementing 0x7F or decrementing 0x80.
- R8: Opcodes 11 (compare) and 12 (compare with borrow) set flags exactly as opcodes 2 and 3 do, but hold the write-enable low.
- R9: Opcode 13 shifts left with a 0 entering bit 0. Opcode 14 shifts right with a 0 entering the MSB. Opcode 17 shifts right and keeps the MSB. C takes the bit shifted out, V becomes N xor C, and H is kept.
- R10: Opcode 15 rotates left through carry and opcode 16 rotates right through carry. The old C enters the vacated end and the bit shifted out becomes C. V becomes N xor C.
- R11: Opcode 18 exchanges the upper and lower halves of opa, writes the result and leaves the whole status byte unchanged.
- R12: The status byte layout is C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5. Whenever N or V is updated, S equals the new N xor V. Bits 7:6 always pass through.
- R13: Opcodes 19 to 31 hold the write-enable low and pass the status byte through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| opa_i | input | DATA_W | First operand (destination register value) |
| opb_i | input | DATA_W | Second operand (register or immediate) |
| sreg_i | input | 8 | Current status byte |
| res_o | output | DATA_W | Operation result |
| res_we_o | output | 1 | Result write-enable |
| sreg_o | output | 8 | Next status byte |

## Verification
The bench builds the block with DATA_W set to 8, the byte width. At that width the signed limits 0x7F and 0x80, the nibble boundary for H and the all-ones value are hit directly. Random operands and random incoming status bytes cover every operation, so every held flag is seen at both 0 and 1. Directed cases cover the overflow edges of increment, decrement and negate, the Z chaining of the borrow forms, and the undefined opcodes.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int SREG_W = 8;
    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
        OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_CMP  = 5'd11,
        OP_CPC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
        logic h;
    } flag_upd_t;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hc,
    output logic         ovf
);
    localparam int HB = W / 2;

    logic [W-1:0]  b_eff;
    logic          c0;
    logic [W:0]    full;
    logic [HB:0]   low;

    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        low   = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c0};
        sum   = full[W-1:0];
        cout  = full[W] ^ sub;
        hc    = low[HB] ^ sub;
        ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] r
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (fn)
                2'd0:    r[i] = a[i] & b[i];
                2'd1:    r[i] = a[i] | b[i];
                2'd2:    r[i] = a[i] ^ b[i];
                default: r[i] = ~a[i];
            endcase
        end
    end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  alu_op_e      sel,
    output logic [W-1:0] r,
    output logic         cout
);
    localparam int HB = W / 2;

    always_comb begin
        r    = a;
        cout = 1'b0;
        case (sel)
            OP_LSL:  begin r = {a[W-2:0], 1'b0};   cout = a[W-1]; end
            OP_LSR:  begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
            OP_ROL:  begin r = {a[W-2:0], cin};    cout = a[W-1]; end
            OP_ROR:  begin r = {cin, a[W-1:1]};    cout = a[0];   end
            OP_ASR:  begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
            OP_SWAP: begin r = {a[HB-1:0], a[W-1:HB]};            end
            default: begin r = a;                  cout = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [SREG_W-1:0] sreg_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_we_o,
    output logic [SREG_W-1:0] sreg_o
);
    localparam int MSB = DATA_W - 1;

    alu_op_e op;
    assign op = alu_op_e'(op_i);

    logic [DATA_W-1:0] as_a, as_b, as_sum;
    logic              as_cin, as_sub, as_co, as_hc, as_ov;
    logic [1:0]        lg_fn;
    logic [DATA_W-1:0] lg_r, sh_r;
    logic              sh_co;

    always_comb begin
        as_a   = opa_i;
        as_b   = opb_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:         as_cin = sreg_i[FC];
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = sreg_i[FC]; end
            OP_NEG:         begin as_a = '0; as_b = opa_i; as_sub = 1'b1; end
            OP_INC:         as_b = DATA_W'(1);
            OP_DEC:         begin as_b = DATA_W'(1); as_sub = 1'b1; end
            default:        as_cin = 1'b0;
        endcase
        case (op)
            OP_AND:  lg_fn = 2'd0;
            OP_OR:   lg_fn = 2'd1;
            OP_XOR:  lg_fn = 2'd2;
            default: lg_fn = 2'd3;
        endcase
    end

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_co), .hc(as_hc), .ovf(as_ov)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a(opa_i), .b(opb_i), .fn(lg_fn), .r(lg_r)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a(opa_i), .cin(sreg_i[FC]), .sel(op), .r(sh_r), .cout(sh_co)
    );

    flag_upd_t upd;
    logic      c_new, v_new, h_new, z_chain, z_new;

    always_comb begin
        res_o    = opa_i;
        res_we_o = 1'b1;
        upd      = '0;
        c_new    = 1'b0;
        v_new    = 1'b0;
        h_new    = 1'b0;
        z_chain  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CPC: begin
                res_o    = as_sum;
                c_new    = as_co;
                v_new    = as_ov;
                h_new    = as_hc;
                upd      = '{c: 1'b1, z: 1'b1, n: 1'b1, v: 1'b1, h: 1'b1};
                z_chain  = (op == OP_SBC) || (op == OP_CPC);
                res_we_o = !((op == OP_CMP) || (op == OP_CPC));
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_o = lg_r;
                upd   = '{c: 1'b0, z: 1'b1, n: 1'b1, v: 1'b1, h: 1'b0};
            end
            OP_COM: begin
                res_o = lg_r;
                c_new = 1'b1;
                upd   = '{c: 1'b1, z: 1'b1, n: 1'b1, v: 1'b1, h: 1'b0};
            end
            OP_INC, OP_DEC: begin
                res_o = as_sum;
                v_new = as_ov;
                upd   = '{c: 1'b0, z: 1'b1, n: 1'b1, v: 1'b1, h: 1'b0};
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                res_o = sh_r;
                c_new = sh_co;
                v_new = sh_r[MSB] ^ sh_co;
                upd   = '{c: 1'b1, z: 1'b1, n: 1'b1, v: 1'b1, h: 1'b0};
            end
            OP_SWAP: res_o = sh_r;
            default: res_we_o = 1'b0;
        endcase

        z_new  = (res_o == '0) && (!z_chain || sreg_i[FZ]);
        sreg_o = sreg_i;
        if (upd.c) sreg_o[FC] = c_new;
        if (upd.z) sreg_o[FZ] = z_new;
        if (upd.n) sreg_o[FN] = res_o[MSB];
        if (upd.v) sreg_o[FV] = v_new;
        if (upd.h) sreg_o[FH] = h_new;
        if (upd.n || upd.v) sreg_o[FS] = sreg_o[FN] ^ sreg_o[FV];
    end
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic [SREG_W-1:0] sreg_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_we_o,
    input logic [SREG_W-1:0] sreg_o
);
    always_comb begin
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) begin
            a_r4_logic_keeps_ch: assert (sreg_o[FC] == sreg_i[FC] && sreg_o[FH] == sreg_i[FH] && !sreg_o[FV])
                else $error("R4 logic op disturbed C/H or left V set");
        end
        if (op_i == OP_INC || op_i == OP_DEC) begin
            a_r7_incdec_keeps_carry: assert (sreg_o[FC] == sreg_i[FC] && sreg_o[FH] == sreg_i[FH])
                else $error("R7 increment/decrement changed C or H");
        end
        if (op_i == OP_CMP || op_i == OP_CPC) begin
            a_r8_compare_no_write: assert (!res_we_o)
                else $error("R8 compare asserted write-enable");
        end
        if (op_i == OP_SBC || op_i == OP_CPC) begin
            a_r3_zero_never_set: assert (!sreg_o[FZ] || sreg_i[FZ])
                else $error("R3 chained op newly set Z");
        end
        if (op_i == OP_SWAP) begin
            a_r11_swap_flags_kept: assert (res_we_o && sreg_o == sreg_i)
                else $error("R11 swap altered status or dropped write");
        end
        if (op_i > OP_SWAP) begin
            a_r13_undef_inert: assert (!res_we_o && sreg_o == sreg_i)
                else $error("R13 undefined opcode had an effect");
        end
        a_r12_upper_bits_kept: assert (sreg_o[SREG_W-1:FH+1] == sreg_i[SREG_W-1:FH+1])
            else $error("R12 upper status bits changed");
    end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
    .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .sreg_i(sreg_i),
    .res_o(res_o), .res_we_o(res_we_o), .sreg_o(sreg_o)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    op;
    logic [DW-1:0] a, b;
    logic [7:0]    s;
    logic [DW-1:0] res;
    logic          we;
    logic [7:0]    so;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core #(.DATA_W(DW)) u_alu8_core (
        .op_i(op), .opa_i(a), .opb_i(b), .sreg_i(s),
        .res_o(res), .res_we_o(we), .sreg_o(so)
    );

    function automatic string req_of(input int o);
        case (o)
            0, 1:             return "R1,R12";
            2:                return "R2,R12";
            3:                return "R2,R3";
            4, 5, 6:          return "R4,R12";
            7:                return "R5";
            8:                return "R6";
            9, 10:            return "R7";
            11:               return "R8";
            12:               return "R8,R3";
            13, 14, 17:       return "R9";
            15, 16:           return "R10";
            18:               return "R11";
            default:          return "R13";
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // returns {we, result, status}
    function automatic logic [16:0] model(input int o, input int ai, input int bi, input logic [7:0] si);
        logic [7:0] ns;
        int r, t, c, cin, sv, hl;
        bit w, upd_nv, chain;
        ns = si; w = 1; upd_nv = 0; chain = 0; r = ai;
        c = si[0];
        case (o)
            0, 1: begin
                cin = (o == 1) ? c : 0;
                t = ai + bi + cin; r = t & 255;
                ns[0] = (t > 255);
                ns[5] = ((ai & 15) + (bi & 15) + cin) > 15;
                sv = sgn(ai) + sgn(bi) + cin;
                ns[3] = (sv > 127) || (sv < -128);
                upd_nv = 1;
            end
            2, 3, 8, 11, 12: begin
                int x, y;
                x = (o == 8) ? 0 : ai;
                y = (o == 8) ? ai : bi;
                cin = (o == 3 || o == 12) ? c : 0;
                chain = (o == 3 || o == 12);
                t = x - y - cin; r = t & 255;
                ns[0] = (t < 0);
                hl = (x & 15) - (y & 15) - cin;
                ns[5] = (hl < 0);
                sv = sgn(x) - sgn(y) - cin;
                ns[3] = (sv > 127) || (sv < -128);
                w = !(o == 11 || o == 12);
                upd_nv = 1;
            end
            4: begin r = ai & bi; ns[3] = 0; upd_nv = 1; end
            5: begin r = ai | bi; ns[3] = 0; upd_nv = 1; end
            6: begin r = ai ^ bi; ns[3] = 0; upd_nv = 1; end
            7: begin r = 255 - ai; ns[0] = 1; ns[3] = 0; upd_nv = 1; end
            9: begin r = (ai + 1) & 255; ns[3] = (ai == 127); upd_nv = 1; end
            10: begin r = (ai + 255) & 255; ns[3] = (ai == 128); upd_nv = 1; end
            13, 14, 15, 16, 17: begin
                case (o)
                    13: begin r = (ai * 2) & 255; ns[0] = ai[7]; end
                    14: begin r = ai / 2; ns[0] = ai[0]; end
                    15: begin r = ((ai * 2) & 255) | c; ns[0] = ai[7]; end
                    16: begin r = (ai / 2) | (c * 128); ns[0] = ai[0]; end
                    default: begin r = (ai / 2) | (ai & 128); ns[0] = ai[0]; end
                endcase
                ns[3] = ((r >> 7) & 1) ^ ns[0];
                upd_nv = 1;
            end
            18: r = ((ai & 15) * 16) | (ai / 16);
            default: w = 0;
        endcase
        if (upd_nv) begin
            ns[1] = (r == 0) && (!chain || si[1]);
            ns[2] = (r >> 7) & 1;
            ns[4] = ns[2] ^ ns[3];
        end
        return {w, r[7:0], ns};
    endfunction

    task automatic run(input int o, input int ai, input int bi, input logic [7:0] si);
        logic [16:0] e;
        @(negedge clk);
        op = o[4:0]; a = ai[7:0]; b = bi[7:0]; s = si;
        #1;
        e = model(o, ai, bi, si);
        checks++;
        if (we !== e[16] || so !== e[7:0] || (e[16] && res !== e[15:8])) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h s=%02h: got we=%0b res=%02h sreg=%02h, expected we=%0b res=%02h sreg=%02h",
                     req_of(o), o, ai, bi, si, we, res, so, e[16], e[15:8], e[7:0]);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, got no finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op = 5'd0; a = '0; b = '0; s = 8'h00;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        // idle state after reset: add of zeros yields Z only (R1)
        run(0, 0, 0, 8'h00);
        // R1 corners
        run(0, 8'h7F, 8'h01, 8'h00);
        run(0, 8'hFF, 8'h01, 8'h00);
        run(1, 8'h0F, 8'h00, 8'h01);
        // R2 corners
        run(2, 8'h80, 8'h01, 8'h00);
        run(2, 8'h10, 8'h01, 8'h00);
        // R3 chain: equal bytes, borrow clear, Z clear in -> Z stays clear
        run(3, 8'h42, 8'h42, 8'h00);
        run(3, 8'h42, 8'h42, 8'h02);
        run(12, 8'h05, 8'h04, 8'h03);
        run(12, 8'h05, 8'h05, 8'h01);
        // R4, R5
        run(4, 8'hF0, 8'h0F, 8'h3F);
        run(6, 8'h80, 8'h00, 8'h08);
        run(7, 8'hFF, 8'h00, 8'h20);
        // R6
        run(8, 8'h80, 8'h00, 8'h00);
        run(8, 8'h00, 8'h00, 8'h3F);
        run(8, 8'h01, 8'h00, 8'h00);
        // R7
        run(9, 8'h7F, 8'h00, 8'h21);
        run(10, 8'h80, 8'h00, 8'h00);
        run(10, 8'h00, 8'h00, 8'h21);
        run(9, 8'hFF, 8'h00, 8'h00);
        // R8
        run(11, 8'h10, 8'h20, 8'h00);
        // R9, R10
        run(13, 8'h80, 8'h00, 8'h20);
        run(14, 8'h01, 8'h00, 8'h00);
        run(17, 8'h81, 8'h00, 8'h00);
        run(15, 8'h80, 8'h00, 8'h01);
        run(16, 8'h01, 8'h00, 8'h01);
        run(16, 8'h00, 8'h00, 8'h01);
        // R11, R13
        run(18, 8'hA5, 8'h00, 8'hFF);
        run(19, 8'h12, 8'h34, 8'hC3);
        run(31, 8'h00, 8'h00, 8'h00);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            int o;
            if (($urandom % 8) == 0) o = 19 + int'($urandom % 13);
            else                     o = int'($urandom % 19);
            run(o, int'($urandom % 256), int'($urandom % 256), 8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule